// File: doc/BRIEF.md
# Dual-CPU Bus Ownership Controller

This block picks which of two processors owns a shared system bus. One is an 8-bit processor with a separate I/O space. The other is a wide processor with a 24-bit address space, which reaches I/O ports through memory-mapped stores.

Ownership moves through a single control port, number 0xFF. The 8-bit processor reaches it with an I/O write. The wide processor reaches it with a store to the top byte of its address space.

The block watches the write strobe of the processor that owns the bus. It records a hit on the control port and the data bit written. When the strobe drops, the bus cycle is complete, and the block changes owner on the next clock edge. The processor that gives up the bus is then held idle. The 8-bit processor is held through a bus request. The wide processor is held through its reset input until it has run once, and through its halt input after that.

Because of this, the first start of the wide processor begins with its reset-vector fetch. Every later start resumes the suspended program. A registered first-run flag records which case applies. The only data line the block samples is D0 of each processor.

Top module: `dual_cpu_bus_owner`

## Requirements
- R1: After reset, the 8-bit processor owns the bus: `owner_narrow_o`=1, `owner_wide_o`=0, `bus_sel_o`=0, `narrow_busreq_o`=0, `wide_rst_o`=1, `wide_halt_o`=0.
- R2: When the 8-bit processor owns the bus and writes D0=1 to I/O port 0xFF, ownership passes to the wide processor.
- R3: When the wide processor owns the bus and stores D0=0 at address 0xFFFFFF, ownership returns to the 8-bit processor.
- R4: A wide store reaches the control port only when address bits 23:16 are 0xFF, bits 15:8 are 0xFF and bits 7:0 are 0xFF. A store to any other address has no effect.
- R5: A handover never happens while the write strobe is high. It takes effect at the first clock edge at which the strobe that carried the hit is sampled low.
- R6: The first release of the wide processor after reset is made by deasserting `wide_rst_o`. `wide_rst_o` then stays low until the next reset.
- R7: Once the wide processor has run, it is idled by `wide_halt_o`=1 while the 8-bit processor owns the bus. It is resumed by `wide_halt_o`=0, and `wide_rst_o` stays low throughout.
- R8: Exactly one of `owner_narrow_o` and `owner_wide_o` is high at all times. `bus_sel_o` and `narrow_busreq_o` equal `owner_wide_o` in the same cycle.
- R9: Only D0 is examined, so a written byte of 0x03 acts as 1 and 0xFE acts as 0. A write whose D0 selects the current owner changes nothing.
- R10: Writes from the processor that does not own the bus are ignored.
- R11: An 8-bit I/O write to any port other than 0xFF has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| n_io_addr_i | input | 8 | I/O port address from the 8-bit processor |
| n_io_wr_i | input | 1 | I/O write strobe from the 8-bit processor; high for the length of the bus cycle |
| n_d0_i | input | 1 | Data bit 0 from the 8-bit processor |
| w_addr_i | input | 24 | Byte address from the wide processor |
| w_wr_i | input | 1 | Write strobe from the wide processor; high for the length of the bus cycle |
| w_d0_i | input | 1 | Data bit 0 from the wide processor |
| owner_narrow_o | output | 1 | The 8-bit processor owns the bus |
| owner_wide_o | output | 1 | The wide processor owns the bus |
| bus_sel_o | output | 1 | Bus multiplexer select; 1 selects the wide processor |
| narrow_busreq_o | output | 1 | Bus request that holds the 8-bit processor off the bus |
| wide_rst_o | output | 1 | Reset hold for the wide processor before its first run |
| wide_halt_o | output | 1 | Halt hold for the wide processor after its first run |

## Verification
The assertions check the following on every cycle:
- The owner indication is one-hot.
- An owned wide processor is free of both holds, and the 8-bit processor is requested off the bus.
- An idle wide processor is held by exactly one of reset or halt.
- Once released, the reset hold never comes back.
- Every change of owner follows a strobe that was high two edges earlier and low at the last edge.

The bench scenarios cover what depends on the values written. It sweeps every 8-bit port number, every single-bit miss of the wide control address, D0 against the upper data bits, and writes from the processor that is not the owner. It also covers the sequence from the first start to later resumes, and a reset in the middle of a run.

// File: rtl/dcpu_pkg.sv
package dcpu_pkg;
  typedef enum logic {
    OWN_NARROW = 1'b0,
    OWN_WIDE   = 1'b1
  } owner_e;
endpackage

// File: rtl/dcpu_port_snoop.sv
// Watches one processor's writes for the control port. Reports a request
// once the strobe that hit has dropped, i.e. the bus cycle has completed.
module dcpu_port_snoop #(
  parameter int unsigned            ADDR_W     = 8,
  parameter int unsigned            PORT_W     = 8,
  parameter bit                     MEM_MAPPED = 1'b0,
  parameter logic [PORT_W-1:0]      PORT       = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              owner_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              d0_i,
  output logic              req_o,
  output logic              val_o
);
  logic hit;
  logic hit_q;
  logic val_q;

  generate
    if (MEM_MAPPED) begin : g_mmio
      localparam int unsigned PAGE_W = ADDR_W - PORT_W;
      // I/O window: all upper bits set, low bits carry the port
      assign hit = (addr_i[ADDR_W-1:PORT_W] == {PAGE_W{1'b1}}) &&
                   (addr_i[PORT_W-1:0] == PORT);
    end else begin : g_iosp
      assign hit = (addr_i == ADDR_W'(PORT));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q <= 1'b0;
      val_q <= 1'b0;
    end else if (wr_i) begin
      if (owner_i && hit) begin
        hit_q <= 1'b1;
        val_q <= d0_i;
      end
    end else begin
      hit_q <= 1'b0;
    end
  end

  assign req_o = hit_q & ~wr_i;
  assign val_o = val_q;
endmodule

// File: rtl/dcpu_handover.sv
module dcpu_handover
  import dcpu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   n_req_i,
  input  logic   n_val_i,
  input  logic   w_req_i,
  input  logic   w_val_i,
  output owner_e owner_o,
  output logic   ran_o
);
  owner_e owner_q, owner_d;
  logic   ran_q;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NARROW: if (n_req_i &&  n_val_i) owner_d = OWN_WIDE;
      OWN_WIDE:   if (w_req_i && !w_val_i) owner_d = OWN_NARROW;
      default:    owner_d = OWN_NARROW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q <= OWN_NARROW;
      ran_q   <= 1'b0;
    end else begin
      owner_q <= owner_d;
      ran_q   <= ran_q | (owner_d == OWN_WIDE);
    end
  end

  assign owner_o = owner_q;
  assign ran_o   = ran_q;
endmodule

// File: rtl/dcpu_grant_drive.sv
module dcpu_grant_drive
  import dcpu_pkg::*;
(
  input  owner_e owner_i,
  input  logic   ran_i,
  output logic   owner_narrow_o,
  output logic   owner_wide_o,
  output logic   bus_sel_o,
  output logic   narrow_busreq_o,
  output logic   wide_rst_o,
  output logic   wide_halt_o
);
  logic wide;

  assign wide            = (owner_i == OWN_WIDE);
  assign owner_wide_o    = wide;
  assign owner_narrow_o  = ~wide;
  assign bus_sel_o       = wide;
  assign narrow_busreq_o = wide;
  // before first run the core sits in reset; afterwards halt parks it
  assign wide_rst_o      = ~ran_i;
  assign wide_halt_o     = ran_i & ~wide;
endmodule

// File: rtl/dual_cpu_bus_owner.sv
module dual_cpu_bus_owner
  import dcpu_pkg::*;
#(
  parameter int unsigned       N_ADDR_W  = 8,
  parameter int unsigned       W_ADDR_W  = 24,
  parameter logic [7:0]        CTRL_PORT = 8'hFF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_ADDR_W-1:0] n_io_addr_i,
  input  logic                n_io_wr_i,
  input  logic                n_d0_i,
  input  logic [W_ADDR_W-1:0] w_addr_i,
  input  logic                w_wr_i,
  input  logic                w_d0_i,
  output logic                owner_narrow_o,
  output logic                owner_wide_o,
  output logic                bus_sel_o,
  output logic                narrow_busreq_o,
  output logic                wide_rst_o,
  output logic                wide_halt_o
);
  localparam int unsigned PORT_W = 8;

  owner_e owner;
  logic   ran;
  logic   n_req, n_val, w_req, w_val;

  dcpu_port_snoop #(
    .ADDR_W(N_ADDR_W), .PORT_W(PORT_W), .MEM_MAPPED(1'b0), .PORT(CTRL_PORT)
  ) u_snoop_n (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .owner_i(owner == OWN_NARROW),
    .addr_i (n_io_addr_i),
    .wr_i   (n_io_wr_i),
    .d0_i   (n_d0_i),
    .req_o  (n_req),
    .val_o  (n_val)
  );

  dcpu_port_snoop #(
    .ADDR_W(W_ADDR_W), .PORT_W(PORT_W), .MEM_MAPPED(1'b1), .PORT(CTRL_PORT)
  ) u_snoop_w (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .owner_i(owner == OWN_WIDE),
    .addr_i (w_addr_i),
    .wr_i   (w_wr_i),
    .d0_i   (w_d0_i),
    .req_o  (w_req),
    .val_o  (w_val)
  );

  dcpu_handover u_handover (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .n_req_i(n_req),
    .n_val_i(n_val),
    .w_req_i(w_req),
    .w_val_i(w_val),
    .owner_o(owner),
    .ran_o  (ran)
  );

  dcpu_grant_drive u_drive (
    .owner_i        (owner),
    .ran_i          (ran),
    .owner_narrow_o (owner_narrow_o),
    .owner_wide_o   (owner_wide_o),
    .bus_sel_o      (bus_sel_o),
    .narrow_busreq_o(narrow_busreq_o),
    .wide_rst_o     (wide_rst_o),
    .wide_halt_o    (wide_halt_o)
  );
endmodule

// File: rtl/dual_cpu_bus_owner_chk.sv
module dual_cpu_bus_owner_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic n_io_wr_i,
  input logic w_wr_i,
  input logic owner_narrow_o,
  input logic owner_wide_o,
  input logic bus_sel_o,
  input logic narrow_busreq_o,
  input logic wide_rst_o,
  input logic wide_halt_o
);
  p_onehot_owner_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({owner_narrow_o, owner_wide_o}) == 1);

  p_wide_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_wide_o |-> (narrow_busreq_o && bus_sel_o && !wide_rst_o && !wide_halt_o));

  p_enter_after_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(owner_wide_o) |-> (!$past(n_io_wr_i) && $past(n_io_wr_i, 2)));

  p_exit_after_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(owner_wide_o) |-> (!$past(w_wr_i) && $past(w_wr_i, 2)));

  p_rst_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_rst_o |=> !wide_rst_o);

  p_idle_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_narrow_o |-> (wide_rst_o ^ wide_halt_o));
endmodule

bind dual_cpu_bus_owner dual_cpu_bus_owner_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .n_io_wr_i      (n_io_wr_i),
  .w_wr_i         (w_wr_i),
  .owner_narrow_o (owner_narrow_o),
  .owner_wide_o   (owner_wide_o),
  .bus_sel_o      (bus_sel_o),
  .narrow_busreq_o(narrow_busreq_o),
  .wide_rst_o     (wide_rst_o),
  .wide_halt_o    (wide_halt_o)
);

// File: tb/dual_cpu_bus_owner_bench.sv
`timescale 1ns/1ps
module dual_cpu_bus_owner_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  n_io_addr_i = '0;
  logic        n_io_wr_i = 1'b0;
  logic        n_d0_i = 1'b0;
  logic [23:0] w_addr_i = '0;
  logic        w_wr_i = 1'b0;
  logic        w_d0_i = 1'b0;
  logic owner_narrow_o, owner_wide_o, bus_sel_o, narrow_busreq_o, wide_rst_o, wide_halt_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit m_wide = 1'b0;
  bit m_ran  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dual_cpu_bus_owner u_dual_cpu_bus_owner (.*);

  task automatic check_state(input string tag);
    logic [5:0] act, exp;
    act = {owner_narrow_o, owner_wide_o, bus_sel_o, narrow_busreq_o, wide_rst_o, wide_halt_o};
    exp = {~m_wide, m_wide, m_wide, m_wide, ~m_ran, m_ran & ~m_wide};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs {nar,wide,sel,breq,wrst,whalt} act=%b exp=%b", tag, act, exp);
    end
  endtask

  // strobe high for len edges, checked unchanged mid-cycle, result visible after the next edge
  task automatic narrow_wr(input logic [7:0] port, input logic [7:0] data, input int len, input string tag);
    @(negedge clk_i);
    n_io_addr_i = port; n_d0_i = data[0]; n_io_wr_i = 1'b1;
    repeat (len) @(negedge clk_i);
    check_state({"R5 strobe high ", tag});
    n_io_wr_i = 1'b0;
    #1 check_state({"R5 strobe just low ", tag});
    @(posedge clk_i); #1;
    if (!m_wide && port == 8'hFF && data[0]) begin m_wide = 1'b1; m_ran = 1'b1; end
    check_state(tag);
  endtask

  task automatic wide_wr(input logic [23:0] addr, input logic [7:0] data, input int len, input string tag);
    @(negedge clk_i);
    w_addr_i = addr; w_d0_i = data[0]; w_wr_i = 1'b1;
    repeat (len) @(negedge clk_i);
    check_state({"R5 strobe high ", tag});
    w_wr_i = 1'b0;
    @(posedge clk_i); #1;
    if (m_wide && addr == 24'hFFFFFF && !data[0]) m_wide = 1'b0;
    check_state(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #1 check_state("R1 in reset");
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1 check_state("R1 after reset");

    // R11 every other port ignored
    for (int p = 0; p < 255; p++) narrow_wr(8'(p), 8'h01, 1 + p % 3, "R11 other port");
    narrow_wr(8'hFF, 8'h00, 1, "R9 d0=0 to current owner");
    narrow_wr(8'hFF, 8'hFE, 2, "R9 upper bits ignored");
    wide_wr(24'hFFFFFF, 8'h00, 1, "R10 wide write while idle");

    narrow_wr(8'hFF, 8'h03, 3, "R2 R6 first activation");
    narrow_wr(8'hFF, 8'h00, 1, "R10 narrow write while wide owns");

    for (int b = 0; b < 24; b++) wide_wr(24'hFFFFFF ^ (24'h1 << b), 8'h00, 1, "R4 address miss");
    wide_wr(24'hFFFFFF, 8'h01, 2, "R9 wide d0=1 to current owner");
    wide_wr(24'hFFFFFF, 8'hFE, 2, "R3 R7 return to narrow");

    for (int k = 1; k <= 4; k++) begin
      narrow_wr(8'hFF, 8'h01, k, "R2 R7 resume via halt");
      wide_wr(24'hFFFFFF, 8'h00, k, "R3 R7 park via halt");
    end

    // D0 sweep against upper data bits
    for (int d = 0; d < 256; d++) begin
      narrow_wr(8'hFF, 8'(d), 1, "R9 narrow d0 sweep");
      if (m_wide) wide_wr(24'hFFFFFF, 8'(d & 8'hFE), 1, "R9 wide d0 sweep");
    end

    // mid-run reset clears first-run
    narrow_wr(8'hFF, 8'h01, 1, "R2 before reset");
    @(negedge clk_i); rst_ni = 1'b0; m_wide = 1'b0; m_ran = 1'b0;
    #1 check_state("R1 reset mid-run");
    @(negedge clk_i); rst_ni = 1'b1;
    @(posedge clk_i); #1 check_state("R1 R6 after second reset");
    narrow_wr(8'hFF, 8'h01, 2, "R6 first activation again");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule